// File: doc/BRIEF.md
# Load and Shift Clock Divider

This block takes a pixel-rate clock and produces two slower clocks from it. The first is a load clock for a video DAC. A 3-bit code selects its divide ratio, and the duty cycle stays at one half even when the ratio is odd. The second clock comes from the load clock through a second divider whose ratio is a 9-bit field plus one. With a ratio of one, the second clock is a copy of the load clock.

A gate can hold the second clock low while a blanking input is low. This lets the second clock act as a shift clock that starts and stops on whole load pulses. A static test selection hands the load output to a register bit. The second divider then counts that bit's rising edges. Every control arrives as a parallel input field.

Top module: `load_shift_divider`

## Requirements
- R1: `ld_code` selects the load divide ratio in pixel clocks as follows: 0→3, 1→4, 2→4, 3→5, 4→6, 5→8, 6→8, 7→10.
- R2: For an even ratio M, `load_clk` rises on the pixel rising edge that starts a period and stays high for M/2 pixel cycles.
- R3: For an odd ratio M, `load_clk` rises on the pixel falling edge half a cycle into the period and stays high for M half-cycles, which gives exactly 50% duty.
- R4: While `rst_n` is low, `load_clk` is low and the divider is held in the low half of a divide-by-4 period. The code on `ld_code` first takes effect at the second pixel rising edge after reset is released.
- R5: A new `ld_code` takes effect only at the rising edge that closes the current period, so no shortened pulse is produced.
- R6: The second divide ratio is `sh_div`+1 (1 to 512). For ratios of 2 or more, the count starts at 0 after reset and advances modulo the ratio on each rising edge of the load signal. On each such edge, `shift_clk` goes high when the new count is below ceil(ratio/2) and low otherwise. After reset, `shift_clk` is low.
- R7: With `sh_div` = 0, the ungated `shift_clk` equals `load_clk` at all times.
- R8: With `sh_gate_en` high, `blank` is sampled on each rising edge of the load signal. The sampled value opens or closes the gate at the next falling edge of the load signal, and the gate is closed after reset. While the gate is closed, `shift_clk` is low. With `sh_gate_en` low, `blank` has no effect.
- R9: With `out_sel` = 2'b11, `load_clk` follows `tst_load`, and the second divider counts the rising edges of `tst_load`. The values 2'b00, 2'b01 and 2'b10 all select the divider output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel-rate input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_code | input | 3 | Load divide ratio code |
| sh_div | input | 9 | Second divider ratio minus one |
| sh_gate_en | input | 1 | Enables blank gating of the second output |
| blank | input | 1 | Gate request; high lets the second output run |
| out_sel | input | 2 | 2'b11 selects the static test drive |
| tst_load | input | 1 | Static level for the load output in test selection |
| load_clk | output | 1 | Divided load clock |
| shift_clk | output | 1 | Second divided clock or shift clock |

## Verification
The hardest situation to reach is a ratio change, or a blank transition, that lands partway through a period. The bench therefore changes `ld_code` on chosen pixel cycles inside an odd or even period, so that one period with the old ratio runs into one with the new ratio. It also flips `blank` after cycle counts that differ each time, so that the change falls at varied phases of the load clock. A half-cycle reference model is compared at every rising and falling pixel edge. That model follows the order of the second-stage count and the gate through these boundaries. Test selection is entered and left only while the block is in reset, which avoids a switch-over edge in the middle of a cycle.

// File: rtl/load_shift_divider.sv
module load_shift_divider #(
  parameter int N2W = 9
) (
  input  logic           pix_clk,
  input  logic           rst_n,
  input  logic [2:0]     ld_code,
  input  logic [N2W-1:0] sh_div,
  input  logic           sh_gate_en,
  input  logic           blank,
  input  logic [1:0]     out_sel,
  input  logic           tst_load,
  output logic           load_clk,
  output logic           shift_clk
);
  localparam int CW = 4;

  function automatic logic [CW-1:0] ld_mod(input logic [2:0] c);
    case (c)
      3'd0:       ld_mod = CW'(3);
      3'd1, 3'd2: ld_mod = CW'(4);
      3'd3:       ld_mod = CW'(5);
      3'd4:       ld_mod = CW'(6);
      3'd5, 3'd6: ld_mod = CW'(8);
      default:    ld_mod = CW'(10);
    endcase
  endfunction

  logic [CW-1:0] cnt, mod_act, cnt_nxt, mod_nxt;
  logic          rise_q, fall_q, div_out;
  logic          wrap;

  assign wrap = (cnt == mod_act - CW'(1));

  always_comb begin
    if (wrap) begin
      cnt_nxt = '0;
      mod_nxt = ld_mod(ld_code);
    end else begin
      cnt_nxt = cnt + CW'(1);
      mod_nxt = mod_act;
    end
  end

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= CW'(2);
      mod_act <= CW'(4);
      rise_q  <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      mod_act <= mod_nxt;
      rise_q  <= cnt_nxt < ((mod_nxt + CW'(1)) >> 1);
    end
  end

  always_ff @(negedge pix_clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= rise_q;
  end

  assign div_out  = mod_act[0] ? (rise_q & fall_q) : rise_q;
  assign load_clk = (out_sel == 2'b11) ? tst_load : div_out;

  logic [N2W-1:0] c2, c2_nxt;
  logic [N2W:0]   hi2;
  logic           q2, s1, s2, gate_open;

  assign c2_nxt = (c2 >= sh_div) ? '0 : c2 + N2W'(1);
  assign hi2    = ({1'b0, sh_div} + (N2W+1)'(2)) >> 1;

  always_ff @(posedge load_clk or negedge rst_n) begin
    if (!rst_n) begin
      c2 <= '0;
      q2 <= 1'b0;
      s1 <= 1'b0;
    end else begin
      c2 <= c2_nxt;
      q2 <= {1'b0, c2_nxt} < hi2;
      s1 <= blank;
    end
  end

  always_ff @(negedge load_clk or negedge rst_n) begin
    if (!rst_n) s2 <= 1'b0;
    else        s2 <= s1;
  end

  assign gate_open = !sh_gate_en || s2;
  assign shift_clk = ((sh_div == '0) ? load_clk : q2) & gate_open;
endmodule

module load_shift_divider_chk #(
  parameter int N2W = 9
) (
  input logic           pix_clk,
  input logic           rst_n,
  input logic [3:0]     cnt,
  input logic [3:0]     mod_act,
  input logic [N2W-1:0] sh_div,
  input logic           sh_gate_en,
  input logic [1:0]     out_sel,
  input logic           tst_load,
  input logic           load_clk,
  input logic           shift_clk
);
  p_cnt_range_r5: assert property (@(posedge pix_clk) disable iff (!rst_n)
    cnt < mod_act);

  p_switch_at_end_r5: assert property (@(posedge pix_clk) disable iff (!rst_n)
    !$stable(mod_act) |-> cnt == 4'd0);

  p_legal_ratio_r1: assert property (@(posedge pix_clk) disable iff (!rst_n)
    mod_act inside {4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd10});

  p_copy_load_r7: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (sh_div == '0 && !sh_gate_en) |-> shift_clk == load_clk);

  p_static_drive_r9: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (out_sel == 2'b11 && $past(out_sel) == 2'b11 && $stable(tst_load)) |-> $stable(load_clk));
endmodule

bind load_shift_divider load_shift_divider_chk #(.N2W(N2W)) chk_i (
  .pix_clk(pix_clk), .rst_n(rst_n), .cnt(cnt), .mod_act(mod_act),
  .sh_div(sh_div), .sh_gate_en(sh_gate_en), .out_sel(out_sel),
  .tst_load(tst_load), .load_clk(load_clk), .shift_clk(shift_clk));

// File: tb/load_shift_divider_tb_top.sv
module load_shift_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [2:0] ld_code = 3'd1;
  logic [8:0] sh_div = '0;
  logic       sh_gate_en = 1'b0;
  logic       blank = 1'b1;
  logic [1:0] out_sel = 2'b00;
  logic       tst_load = 1'b0;
  logic       load_clk, shift_clk;

  always #4 clk = ~clk;

  load_shift_divider dut_i (
    .pix_clk(clk), .rst_n(rst_n), .ld_code(ld_code), .sh_div(sh_div),
    .sh_gate_en(sh_gate_en), .blank(blank), .out_sel(out_sel),
    .tst_load(tst_load), .load_clk(load_clk), .shift_clk(shift_clk));

  int    total = 0, bad = 0;
  int    pos = 2, mm = 4, c2 = 0;
  bit    q2 = 0, s1 = 0, s2 = 0, prev = 0, prev_act = 0, done = 0;
  int    halves = 0, last_rise = 0, meas = 0;
  string seg = "R4";

  function automatic int ratio(int c);
    int t[8] = '{3, 4, 4, 5, 6, 8, 8, 10};
    return t[c];
  endfunction

  task automatic chk(bit ok, string tag, int got, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic eval(int ph);
    bit el, es;
    int h, m2;
    string lk, sk;
    if (out_sel == 2'b11) el = tst_load;
    else if (!rst_n) el = 0;
    else begin
      h  = 2 * pos + ph;
      el = (mm % 2 == 1) ? (h >= 1 && h <= mm) : (h < mm);
    end
    if (rst_n) begin
      if (el && !prev) begin
        m2 = int'(sh_div) + 1;
        c2 = (c2 >= m2 - 1) ? 0 : c2 + 1;
        q2 = (c2 < (m2 + 1) / 2);
        s1 = blank;
      end else if (!el && prev) s2 = s1;
    end else begin
      c2 = 0; q2 = 0; s1 = 0; s2 = 0; pos = 2; mm = 4;
    end
    prev = el;
    es = ((sh_div == 0) ? el : q2) & (!sh_gate_en || s2);
    lk = (out_sel == 2'b11) ? "R9" : ((mm % 2 == 1) ? "R3" : "R2");
    sk = sh_gate_en ? "R8" : ((sh_div == 0) ? "R7" : "R6");
    chk(load_clk === el, {seg, "/", lk, " load"}, int'(load_clk), int'(el));
    chk(shift_clk === es, {seg, "/", sk, " shift"}, int'(shift_clk), int'(es));
    halves++;
    if (load_clk && !prev_act) begin
      meas = halves - last_rise;
      last_rise = halves;
    end
    prev_act = load_clk;
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) begin
      pos++;
      if (pos == mm) begin
        pos = 0;
        mm  = ratio(int'(ld_code));
      end
    end
    #2 eval(0);
    @(negedge clk);
    #2 eval(1);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    ld_code = 3'd7;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (20) tick();

    seg = "R1";
    for (int c = 0; c < 8; c++) begin
      ld_code = 3'(c);
      repeat (30) tick();
      chk(meas == 2 * ratio(c), "R1 period in half cycles", meas, 2 * ratio(c));
    end

    seg = "R5";
    ld_code = 3'd4; repeat (13) tick();
    ld_code = 3'd7; tick();
    ld_code = 3'd0; repeat (3) tick();
    ld_code = 3'd3; repeat (2) tick();
    ld_code = 3'd6; repeat (30) tick();

    seg = "R6";
    ld_code = 3'd0;
    for (int i = 0; i < 4; i++) begin
      sh_div = 9'(i * 2 + 1 + i % 2);
      repeat (100) tick();
    end
    sh_div = 9'd511; repeat (3200) tick();
    sh_div = 9'd3; ld_code = 3'd3; repeat (60) tick();

    seg = "R7";
    sh_div = '0;
    for (int i = 0; i < 3; i++) begin
      ld_code = 3'(i * 3);
      repeat (30) tick();
    end

    seg = "R8";
    sh_gate_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      ld_code = 3'(k * 2 + 1);
      sh_div  = (k == 2) ? 9'd2 : 9'd0;
      for (int i = 0; i < 10; i++) begin
        blank = ~blank;
        repeat (7 + i * 3) tick();
      end
    end
    blank = 1'b0; sh_gate_en = 1'b0; sh_div = '0; repeat (20) tick();
    blank = 1'b1;

    seg = "R9";
    rst_n = 1'b0; tick();
    out_sel = 2'b11; sh_div = 9'd2; tick();
    rst_n = 1'b1;
    for (int i = 0; i < 14; i++) begin
      tst_load = ~tst_load;
      repeat (1 + i % 3) tick();
    end
    rst_n = 1'b0; tst_load = 1'b0; tick();
    out_sel = 2'b01; tick();
    rst_n = 1'b1; repeat (30) tick();
    out_sel = 2'b10; repeat (30) tick();

    done = 1;
    summary();
  end
endmodule